// File: doc/BRIEF.md
# Jittered PWM Timing Generator

This block produces the switching rhythm for a current-mode power stage. A cycle counter running on the system clock issues a one-clock cycle start pulse at the top of every switching period. A set/reset latch turns the gate on in the clock after each start. It turns the gate off when one of three comparator trips is accepted, when the duty limit of three quarters of the period runs out, or when the supply is low or the stage is forced off. All durations are counts of the system clock, set by parameters.

Turn-off from an accepted trip or a block input is combinational, so the gate drops in the same clock that the cause is present. The ramp and soft-start comparator trips cannot end a pulse before a minimum on-time has elapsed. The current-limit trip is masked by a leading-edge blanking window, and that window is also an output. While soft-start is still running, the period is fixed at its nominal length. Once soft-start has finished, the period follows a triangular sweep around the nominal value to spread the switching spectrum. The defaults give 100 kHz ±4 % with a 4 ms sweep from a 100 MHz clock.

Top module: `pwm_timing_gen`

## Requirements
- R1: While reset is held, gate_en, blank_win and cycle_start are all 0.
- R2: cycle_start is a one-clock pulse. While softstart_done is low, consecutive pulses are exactly NOM_PERIOD clocks apart.
- R3: The jitter sweep advances only at a cycle start where softstart_done is high. At every JIT_HOLD-th such start, an offset moves by JIT_STEP toward the current limit. It starts upward, is clamped at +JIT_DEV and -JIT_DEV, and reverses direction there. The cycle that begins at the next period boundary lasts NOM_PERIOD plus the offset. A cycle start with softstart_done low sets the offset to 0, the direction to upward and the hold count to 0.
- R4: The gate rises in the clock right after a cycle_start pulse and stays high for one contiguous run. gate_en is never high in a cycle_start clock.
- R5: With no trip or block, gate_en stays high for floor(P*DUTY_NUM/DUTY_DEN) clocks, where P is the period of the current cycle.
- R6: trip_pwm or trip_softstart ends the pulse in the clock in which it is high, provided the gate has already been high for at least MIN_ON clocks. An earlier trip holds the pulse to exactly MIN_ON clocks.
- R7: blank_win is high during the first min(width, LEB) clocks of each pulse. trip_ilim has no effect while blank_win is high. After that window it ends the pulse in the clock in which it is high.
- R8: While supply_low is high, gate_en is 0 in the same clock and no pulse starts, regardless of minimum on-time or blanking.
- R9: While force_off is high, gate_en is 0 in the same clock and no pulse starts, regardless of minimum on-time or blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_low | input | 1 | Supply below the under-voltage threshold; holds the gate off |
| force_off | input | 1 | Global disable; holds the gate off |
| softstart_done | input | 1 | High once soft-start is over; enables the jitter sweep |
| trip_pwm | input | 1 | Ramp comparator trip |
| trip_softstart | input | 1 | Soft-start comparator trip |
| trip_ilim | input | 1 | Peak current-limit trip |
| gate_en | output | 1 | Gate enable for the power switch |
| blank_win | output | 1 | Leading-edge blanking window for current-sense trips |
| cycle_start | output | 1 | One-clock pulse at the start of each switching period |

## Verification
The bench drives the trips and blocks relative to the position inside each period. It then checks, cycle by cycle, the measured period, pulse width, blanking length and rise position. Early ramp and soft-start trips are aimed at the minimum-on floor: a design that ignores that floor cuts the pulse short. Early current-limit trips are aimed at the blanking window: a design that does not mask them during the window cuts the pulse short. The supply-low and force-off blocks are applied below the minimum on-time, where a design that lets the floor win would keep the gate on too long. A full triangular sweep, including both turnarounds and the return to nominal when soft-start drops, exposes off-by-one errors in the hold count, the clamps and the clock at which a new period takes effect.

// File: rtl/pwm_timing_pkg.sv
// Shared types and helpers for the jittered PWM timing generator.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package pwm_timing_pkg;

    // Direction of the triangular period sweep
    typedef enum logic {
        SWEEP_UP = 1'b0,
        SWEEP_DN = 1'b1
    } sweep_dir_e;

    // Bits needed to hold values 0..max_val
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/pwm_jitter_sweep.sv
// Triangular period sweep. At each advance pulse with jit_en high, a hold
// count runs; every HOLD-th advance the signed offset moves by STEP,
// clamped at +/-DEV with reversal there. An advance with jit_en low
// returns to offset 0, upward, hold 0. next_period = NOM + offset.
// Assumes: DEV is a multiple of STEP, NOM > DEV, HOLD >= 1.
module pwm_jitter_sweep
    import pwm_timing_pkg::*;
#(
    parameter int NOM  = 1000,
    parameter int DEV  = 40,
    parameter int STEP = 2,
    parameter int HOLD = 5,
    parameter int CW   = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          jit_en,
    output logic [CW-1:0] next_period
);
    localparam int OW = CW + 1;
    localparam int HW = cnt_width(HOLD - 1);
    localparam logic signed [OW-1:0] NOM_S  = OW'(NOM);
    localparam logic signed [OW-1:0] DEV_S  = OW'(DEV);
    localparam logic signed [OW-1:0] STEP_S = OW'(STEP);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD - 1);

    sweep_dir_e             dir_q;
    logic signed [OW-1:0]   off_q;
    logic [HW-1:0]          hold_q;
    logic signed [OW-1:0]   up_val, dn_val, per_s;

    // Candidate offsets one step up and one step down
    always_comb begin
        up_val = off_q + STEP_S;
        dn_val = off_q - STEP_S;
        per_s  = NOM_S + off_q;
    end

    assign next_period = per_s[CW-1:0];

    // Sweep state: offset, direction and hold count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            dir_q  <= SWEEP_UP;
            hold_q <= '0;
        end else if (adv) begin
            if (!jit_en) begin
                off_q  <= '0;
                dir_q  <= SWEEP_UP;
                hold_q <= '0;
            end else if (hold_q == HOLD_LAST) begin
                hold_q <= '0;
                if (dir_q == SWEEP_UP) begin
                    if (up_val >= DEV_S) begin
                        off_q <= DEV_S;
                        dir_q <= SWEEP_DN;
                    end else begin
                        off_q <= up_val;
                    end
                end else begin
                    if (dn_val <= -DEV_S) begin
                        off_q <= -DEV_S;
                        dir_q <= SWEEP_UP;
                    end else begin
                        off_q <= dn_val;
                    end
                end
            end else begin
                hold_q <= hold_q + HW'(1);
            end
        end
    end

endmodule

// File: rtl/pwm_cycle_timer.sv
// Switching period counter. It emits cycle_start when the count is 0,
// loads next_period at each period boundary, and derives the per-cycle
// on-time cap from the latched period.
// Assumes: next_period >= 4, so the duty cap is below the period.
module pwm_cycle_timer #(
    parameter int NOM      = 1000,
    parameter int DUTY_NUM = 3,
    parameter int DUTY_DEN = 4,
    parameter int CW       = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] next_period,
    output logic          cycle_start,
    output logic [CW-1:0] on_max
);
    localparam int PW = CW + $clog2(DUTY_NUM + 1);

    logic [CW-1:0] cnt_q, per_q;
    logic          run_q;
    logic [PW-1:0] prod;

    // Period count with the length latched at each boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= CW'(NOM);
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (run_q) begin
                if (cnt_q == per_q - CW'(1)) begin
                    cnt_q <= '0;
                    per_q <= next_period;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    // Start pulse and duty cap for the current period
    always_comb begin
        cycle_start = run_q && (cnt_q == '0);
        prod        = PW'(per_q) * PW'(DUTY_NUM);
        on_max      = CW'(prod / PW'(DUTY_DEN));
    end

endmodule

// File: rtl/pwm_gate_latch.sv
// Set/reset gate latch. It sets on cycle_start unless blocked. It clears
// on the duty cap or an accepted trip; an accepted trip or block drops
// gate_en in the same clock. Ramp and soft-start trips count only after
// MIN_ON clocks of on-time. The current-limit trip counts only after LEB
// clocks of on-time.
// Assumes: 1 <= LEB, MIN_ON < 2**CW, on_max >= 1.
module pwm_gate_latch #(
    parameter int CW     = 11,
    parameter int MIN_ON = 16,
    parameter int LEB    = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cycle_start,
    input  logic [CW-1:0] on_max,
    input  logic          supply_low,
    input  logic          force_off,
    input  logic          trip_pwm,
    input  logic          trip_softstart,
    input  logic          trip_ilim,
    output logic          gate_en,
    output logic          blank_win
);
    localparam logic [CW-1:0] MIN_ON_C = CW'(MIN_ON);
    localparam logic [CW-1:0] LEB_C    = CW'(LEB);

    logic          gate_q;
    logic [CW-1:0] on_cnt;
    logic          block, kill_cmp, kill_cl, stop_now, duty_end;

    // Turn-off causes, evaluated in the current clock
    always_comb begin
        block     = supply_low || force_off;
        kill_cmp  = gate_q && (trip_pwm || trip_softstart) && (on_cnt >= MIN_ON_C);
        kill_cl   = gate_q && trip_ilim && (on_cnt >= LEB_C);
        stop_now  = block || kill_cmp || kill_cl;
        duty_end  = gate_q && (on_cnt == on_max - CW'(1));
        gate_en   = gate_q && !stop_now;
        blank_win = gate_en && (on_cnt < LEB_C);
    end

    // Latch state and on-time count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            on_cnt <= '0;
        end else if (stop_now || duty_end) begin
            gate_q <= 1'b0;
            on_cnt <= '0;
        end else if (cycle_start) begin
            gate_q <= 1'b1;
            on_cnt <= '0;
        end else if (gate_q) begin
            on_cnt <= on_cnt + CW'(1);
        end
    end

endmodule

// File: rtl/pwm_timing_gen.sv
// Top of the jittered PWM timing generator. It joins the period sweep,
// the cycle timer and the gate latch. With JIT_DEV = 0, a fixed-period
// variant replaces the sweep.
// Assumes: NOM_PERIOD - JIT_DEV >= 4; durations are system clock counts.
module pwm_timing_gen
    import pwm_timing_pkg::*;
#(
    parameter int NOM_PERIOD = 1000,
    parameter int JIT_DEV    = 40,
    parameter int JIT_STEP   = 2,
    parameter int JIT_HOLD   = 5,
    parameter int DUTY_NUM   = 3,
    parameter int DUTY_DEN   = 4,
    parameter int MIN_ON     = 16,
    parameter int LEB        = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic force_off,
    input  logic softstart_done,
    input  logic trip_pwm,
    input  logic trip_softstart,
    input  logic trip_ilim,
    output logic gate_en,
    output logic blank_win,
    output logic cycle_start
);
    localparam int CW = cnt_width(NOM_PERIOD + JIT_DEV);

    logic [CW-1:0] next_period;
    logic [CW-1:0] on_max;

    // Period source: fixed or triangular sweep
    generate
        if (JIT_DEV == 0) begin : g_fixed
            assign next_period = CW'(NOM_PERIOD);
        end else begin : g_sweep
            pwm_jitter_sweep #(
                .NOM  (NOM_PERIOD),
                .DEV  (JIT_DEV),
                .STEP (JIT_STEP),
                .HOLD (JIT_HOLD),
                .CW   (CW)
            ) u_sweep (
                .clk         (clk),
                .rst_n       (rst_n),
                .adv         (cycle_start),
                .jit_en      (softstart_done),
                .next_period (next_period)
            );
        end
    endgenerate

    pwm_cycle_timer #(
        .NOM      (NOM_PERIOD),
        .DUTY_NUM (DUTY_NUM),
        .DUTY_DEN (DUTY_DEN),
        .CW       (CW)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .next_period (next_period),
        .cycle_start (cycle_start),
        .on_max      (on_max)
    );

    pwm_gate_latch #(
        .CW     (CW),
        .MIN_ON (MIN_ON),
        .LEB    (LEB)
    ) u_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .cycle_start    (cycle_start),
        .on_max         (on_max),
        .supply_low     (supply_low),
        .force_off      (force_off),
        .trip_pwm       (trip_pwm),
        .trip_softstart (trip_softstart),
        .trip_ilim      (trip_ilim),
        .gate_en        (gate_en),
        .blank_win      (blank_win)
    );

endmodule

// File: rtl/pwm_timing_chk.sv
// Property checker for pwm_timing_gen, attached by bind. It keeps its own
// count of consecutive gate-on clocks to judge trip acceptance.
// Assumes: MIN_ON and LEB match the bound instance.
module pwm_timing_chk #(
    parameter int MIN_ON = 16,
    parameter int LEB    = 22
) (
    input logic clk,
    input logic rst_n,
    input logic supply_low,
    input logic force_off,
    input logic trip_pwm,
    input logic trip_softstart,
    input logic trip_ilim,
    input logic gate_en,
    input logic blank_win,
    input logic cycle_start
);
    logic [31:0] hi_cnt;

    // Consecutive gate-on clocks seen so far
    always_ff @(posedge clk) begin
        if (!rst_n) hi_cnt <= '0;
        else if (gate_en) hi_cnt <= hi_cnt + 32'd1;
        else hi_cnt <= '0;
    end

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);

    // R4
    rise_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> $past(cycle_start));

    // R4
    off_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> !gate_en);

    // R6
    min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && (trip_pwm || trip_softstart)) |-> (hi_cnt < 32'(MIN_ON)));

    // R7
    ilim_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && trip_ilim) |-> (hi_cnt < 32'(LEB)));

    // R7
    blank_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> blank_win);

    // R8
    supply_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> !gate_en);

    // R9
    force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |-> !gate_en);

endmodule

bind pwm_timing_gen pwm_timing_chk #(
    .MIN_ON (MIN_ON),
    .LEB    (LEB)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_low     (supply_low),
    .force_off      (force_off),
    .trip_pwm       (trip_pwm),
    .trip_softstart (trip_softstart),
    .trip_ilim      (trip_ilim),
    .gate_en        (gate_en),
    .blank_win      (blank_win),
    .cycle_start    (cycle_start)
);

// File: tb/tb_pwm_timing_gen.sv
// Scoreboard bench: the driver pushes one expected record per switching
// cycle; the monitor measures each finished cycle and compares.
module tb_pwm_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NOM    = 40;
    localparam int DEV    = 4;
    localparam int STEP   = 1;
    localparam int HOLD   = 2;
    localparam int MINON  = 3;
    localparam int LEBN   = 5;
    localparam int NONE   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low, force_off, trip_pwm, trip_softstart, trip_ilim;
    logic softstart_done = 1'b0;
    logic gate_en, blank_win, cycle_start;

    int p = 0;
    int at_pwm = NONE, at_ss = NONE, at_ilim = NONE, at_low = NONE, at_off = NONE;
    int checks = 0, errors = 0;

    typedef struct {
        int    period;
        int    width;
        int    blank;
        int    lead;
        string ptag;
        string wtag;
    } exp_t;
    exp_t exp_q[$];

    // Reference sweep model built from R3
    int m_per = NOM, m_off = 0, m_up = 1, m_hold = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Stimulus relative to position p within the period (on-count = p-1)
    assign trip_pwm       = (p >= at_pwm + 1);
    assign trip_softstart = (p >= at_ss + 1);
    assign trip_ilim      = (p >= at_ilim + 1);
    assign supply_low     = (p >= at_low + 1);
    assign force_off      = (p >= at_off + 1);

    pwm_timing_gen #(
        .NOM_PERIOD (NOM),
        .JIT_DEV    (DEV),
        .JIT_STEP   (STEP),
        .JIT_HOLD   (HOLD),
        .DUTY_NUM   (3),
        .DUTY_DEN   (4),
        .MIN_ON     (MINON),
        .LEB        (LEBN)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_low     (supply_low),
        .force_off      (force_off),
        .softstart_done (softstart_done),
        .trip_pwm       (trip_pwm),
        .trip_softstart (trip_softstart),
        .trip_ilim      (trip_ilim),
        .gate_en        (gate_en),
        .blank_win      (blank_win),
        .cycle_start    (cycle_start)
    );

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Position within the period, updated just after each edge
    always @(posedge clk) begin
        #1;
        if (cycle_start) p = 0;
        else p = p + 1;
    end

    // Monitor: measure each finished cycle and compare with the queue
    int  len = 0, wid = 0, bl = 0, first = -1;
    bit  have = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cycle_start) begin
                if (have && exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(len == e.period, e.ptag, "period", len, e.period);
                    check(wid == e.width, e.wtag, "gate width", wid, e.width);
                    check(bl == e.blank, "R7", "blank length", bl, e.blank);
                    check(first == (e.lead ? 1 : -1), "R4", "rise position", first,
                          e.lead ? 1 : -1);
                end
                have  = 1'b1;
                len   = 0;
                wid   = 0;
                bl    = 0;
                first = -1;
            end
            if (have) begin
                if (gate_en) begin
                    if (first < 0) first = len;
                    wid++;
                end
                if (blank_win) bl++;
                len++;
            end
        end
    end

    // Advance the reference sweep at one cycle start (R3)
    task automatic model_adv(input bit ss);
        if (!ss) begin
            m_off = 0; m_up = 1; m_hold = 0;
        end else if (m_hold == HOLD - 1) begin
            m_hold = 0;
            if (m_up != 0) begin
                if (m_off + STEP >= DEV) begin m_off = DEV; m_up = 0; end
                else m_off = m_off + STEP;
            end else begin
                if (m_off - STEP <= -DEV) begin m_off = -DEV; m_up = 1; end
                else m_off = m_off - STEP;
            end
        end else begin
            m_hold++;
        end
    endtask

    // Driver: apply settings for n cycles and push their expected records
    task automatic seg(input int n, input bit ss, input int apw, input int ass,
                       input int ail, input int alw, input int aof, input string wtag);
        softstart_done = ss;
        at_pwm = apw; at_ss = ass; at_ilim = ail; at_low = alw; at_off = aof;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            int w;
            w = (m_per * 3) / 4;
            if (apw != NONE) w = imin(w, imax(apw, MINON));
            if (ass != NONE) w = imin(w, imax(ass, MINON));
            if (ail != NONE) w = imin(w, imax(ail, LEBN));
            if (alw != NONE) w = imin(w, imax(alw, 0));
            if (aof != NONE) w = imin(w, imax(aof, 0));
            e.period = m_per;
            e.width  = w;
            e.blank  = imin(w, LEBN);
            e.lead   = (w > 0) ? 1 : 0;
            e.ptag   = (ss || m_per != NOM) ? "R3" : "R2";
            e.wtag   = wtag;
            exp_q.push_back(e);
            model_adv(ss);
            m_per = NOM + m_off;
        end
        wait (exp_q.size() == 0);
    endtask

    task automatic run_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(gate_en == 1'b0, "R1", "gate_en in reset", gate_en, 0);
        check(blank_win == 1'b0, "R1", "blank_win in reset", blank_win, 0);
        check(cycle_start == 1'b0, "R1", "cycle_start in reset", cycle_start, 0);
        rst_n = 1'b1;
        // R5: free-running duty cap at nominal period (R2)
        seg(3, 0, NONE, NONE, NONE, NONE, NONE, "R5");
        // R6: ramp and soft-start trips, above and below the minimum on-time
        seg(2, 0, 10, NONE, NONE, NONE, NONE, "R6");
        seg(1, 0, 0, NONE, NONE, NONE, NONE, "R6");
        seg(1, 0, NONE, 1, NONE, NONE, NONE, "R6");
        seg(1, 0, NONE, 7, NONE, NONE, NONE, "R6");
        // R7: current-limit trip inside and after blanking
        seg(1, 0, NONE, NONE, 0, NONE, NONE, "R7");
        seg(1, 0, NONE, NONE, 2, NONE, NONE, "R7");
        seg(1, 0, NONE, NONE, 12, NONE, NONE, "R7");
        // R8: low supply from cycle start and mid-pulse below minimum on-time
        seg(2, 0, NONE, NONE, NONE, -1, NONE, "R8");
        seg(1, 0, NONE, NONE, NONE, 1, NONE, "R8");
        seg(1, 0, NONE, NONE, NONE, 2, NONE, "R8");
        // R9: forced off from cycle start and mid-pulse
        seg(2, 0, NONE, NONE, NONE, NONE, -1, "R9");
        seg(1, 0, NONE, NONE, NONE, NONE, 1, "R9");
        seg(1, 0, NONE, NONE, NONE, NONE, NONE, "R5");
        // R3: full triangular sweep with both turnarounds
        seg(36, 1, NONE, NONE, NONE, NONE, NONE, "R5");
        seg(4, 1, 6, NONE, NONE, NONE, NONE, "R6");
        // R3: sweep returns to nominal once soft-start is not complete
        seg(3, 0, NONE, NONE, NONE, NONE, NONE, "R5");
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule